// File: doc/BRIEF.md
# Two-Channel One-Bit Bitstream Decimator

This block turns two one-bit oversampled bitstreams (left and right) into 16-bit two's-complement words at one sixty-fourth of the bit rate. Each channel passes its stream through three cascaded linear-phase FIR stages. The first two stages each keep every second result. The third stage keeps every sixteenth result. The last stage's accumulator is rounded into the 16-bit output range and clamped there, and a per-channel flag marks the samples that had to be clamped.

The caller asserts `ce` once for each oversampled bit period and presents one bit per channel alongside it. The two channels share the enable, so their results appear together under a single one-clock `smp_valid` pulse. The outputs then hold their values until the next pulse. The coefficients are fixed constants computed during elaboration, so the block needs no loading.

Top module: `sdm_decim64`

## Requirements
- R1: When `ce` is high, an input bit of 1 is taken as +1 and a bit of 0 as −1. Filter history before the first accepted bit after reset counts as 0. A steady stream of zeros settles to −32768 with the flag low.
- R2: `smp_valid` is high for exactly one clock per 64 accepted bits. For bits counted from reset, it is high in the cycle after the third rising edge that follows the edge accepting bit 64·(j+1).
- R3: The first and second stages each weight their three newest inputs by 1, 2, 1. Each keeps the result formed when its 2nd, 4th, 6th … input arrives.
- R4: The third stage weights its sixteen newest inputs, newest first, by 509, 1031, 2039, 3079, 4093, 5639, 7159, 9219, then the same eight values in reverse. It keeps the result formed when its 16th, 32nd … input arrives.
- R5: The third-stage sum is rounded by adding 16 and then shifting right arithmetically by 5, which rounds half upward. A full-scale sum of ±2^20 maps to ±2^15.
- R6: A rounded value above 32767 is output as 32767, and one below −32768 as −32768. The channel's flag is 1 exactly when clamping happened for that sample, so a steady all-ones stream gives 32767 with the flag set.
- R7: Each channel's result depends only on its own bitstream. Both channels' results are presented in the same cycle.
- R8: While `ce` is low, no bit is consumed, the bit inputs are ignored and no `smp_valid` pulse is started.
- R9: Between pulses, the sample outputs and flags keep their last values.
- R10: While `rst_n` is low, both samples read 0, both flags and `smp_valid` read 0, and all filter history and decimation phases restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce | input | 1 | Oversampled bit enable |
| bit_l | input | 1 | Left bitstream |
| bit_r | input | 1 | Right bitstream |
| smp_l | output | OUT_W | Left sample, two's complement |
| smp_r | output | OUT_W | Right sample, two's complement |
| ovr_l | output | 1 | Left sample was clamped |
| ovr_r | output | 1 | Right sample was clamped |
| smp_valid | output | 1 | One-clock pulse when new samples are presented |

## Verification
A wrong tap, coefficient or fold index shows up as a wrong sample value on the very next `smp_valid` pulse. The exception is a stale history slot, which can stay hidden until the streams change density. A decimation phase that slips moves the pulse away from the cycle three edges after every 64th accepted bit, so it shows at the first frame boundary. A clamp or rounding slip shows on the frames whose sums lie near full scale or on a half-LSB boundary, and the flag then disagrees with the value in the same cycle.

// File: rtl/decim_pkg.sv
package decim_pkg;

  localparam int N_STG   = 3;
  localparam int IN_BITS = 2;

  function automatic int stg_decim(input int s);
    return (s < 2) ? 2 : 16;
  endfunction

  function automatic int stg_taps(input int s);
    return (s < 2) ? 3 : 16;
  endfunction

  // symmetric weights; index 0 is the newest input
  function automatic int stg_coef(input int s, input int i);
    int k;
    if (s < 2) return (i == 1) ? 2 : 1;
    k = (i < 8) ? i : 15 - i;
    case (k)
      0: return 509;
      1: return 1031;
      2: return 2039;
      3: return 3079;
      4: return 4093;
      5: return 5639;
      6: return 7159;
      7: return 9219;
      default: return 0;
    endcase
  endfunction

  function automatic int stg_gain(input int s);
    int g;
    g = 0;
    for (int i = 0; i < stg_taps(s); i++) g += stg_coef(s, i);
    return g;
  endfunction

  function automatic int stg_gbits(input int s);
    return $clog2(stg_gain(s));
  endfunction

  function automatic int stg_in_w(input int s);
    int w;
    w = IN_BITS;
    for (int i = 0; i < s; i++) w += stg_gbits(i);
    return w;
  endfunction

  localparam int ACC_W   = stg_in_w(N_STG);
  localparam int FS_LOG2 = ACC_W - IN_BITS;

endpackage

// File: rtl/decim_stage.sv
module decim_stage
  import decim_pkg::*;
#(
  parameter int STG  = 0,
  parameter int IN_W = 2,
  localparam int OUT_W = IN_W + stg_gbits(STG)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [IN_W-1:0]  in_dat,
  output logic                    out_vld,
  output logic signed [OUT_W-1:0] out_dat
);

  localparam int DECIM = stg_decim(STG);
  localparam int NTAPS = stg_taps(STG);
  localparam int NPAIR = NTAPS / 2;
  localparam int NPROD = NPAIR + (NTAPS % 2);
  localparam int PH_W  = $clog2(DECIM);

  logic signed [IN_W-1:0]  tap_q [NTAPS];
  logic signed [IN_W-1:0]  tap_d [NTAPS];
  logic signed [OUT_W-1:0] prod  [NPROD];
  logic signed [OUT_W-1:0] acc;
  logic [PH_W-1:0]         ph_q;
  logic                    fire;

  function automatic logic signed [OUT_W-1:0] widen(input logic signed [IN_W-1:0] v);
    return {{(OUT_W-IN_W){v[IN_W-1]}}, v};
  endfunction

  always_comb begin
    tap_d[0] = in_dat;
    for (int i = 1; i < NTAPS; i++) tap_d[i] = tap_q[i-1];
  end

  genvar p;
  for (p = 0; p < NPAIR; p++) begin : g_pair
    localparam logic signed [OUT_W-1:0] CP = OUT_W'(stg_coef(STG, p));
    assign prod[p] = (widen(tap_d[p]) + widen(tap_d[NTAPS-1-p])) * CP;
  end

  if (NTAPS % 2 == 1) begin : g_mid
    localparam logic signed [OUT_W-1:0] CM = OUT_W'(stg_coef(STG, NPAIR));
    assign prod[NPAIR] = widen(tap_d[NPAIR]) * CM;
  end

  always_comb begin
    acc = '0;
    for (int i = 0; i < NPROD; i++) acc = acc + prod[i];
  end

  assign fire = in_vld && (ph_q == PH_W'(DECIM - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NTAPS; i++) tap_q[i] <= '0;
      ph_q    <= '0;
      out_vld <= 1'b0;
      out_dat <= '0;
    end else begin
      out_vld <= fire;
      if (in_vld) begin
        for (int i = 0; i < NTAPS; i++) tap_q[i] <= tap_d[i];
        ph_q <= fire ? '0 : ph_q + 1'b1;
      end
      if (fire) out_dat <= acc;
    end
  end

  // R2
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |=> !out_vld);

  // R8
  idle_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld |-> $past(in_vld));

  // R9
  hold_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_dat));

endmodule

// File: rtl/decim_outfmt.sv
module decim_outfmt #(
  parameter int ACC_W = 22,
  parameter int OUT_W = 16,
  parameter int SH    = 5
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_vld,
  input  logic signed [ACC_W-1:0] in_acc,
  output logic                    smp_vld,
  output logic signed [OUT_W-1:0] smp,
  output logic                    ovr
);

  localparam int QW   = ACC_W + 1 - SH;
  localparam int HALF = 1 << (SH - 1);
  localparam logic signed [QW-1:0] QMAX = QW'((1 << (OUT_W - 1)) - 1);
  localparam logic signed [QW-1:0] QMIN = QW'(-(1 << (OUT_W - 1)));
  localparam logic signed [OUT_W-1:0] OMAX = OUT_W'(QMAX);
  localparam logic signed [OUT_W-1:0] OMIN = OUT_W'(QMIN);

  // returns {clamped, value}
  function automatic logic [OUT_W:0] round_sat(input logic signed [ACC_W-1:0] a);
    logic signed [ACC_W:0] t;
    logic signed [QW-1:0]  q;
    t = $signed({a[ACC_W-1], a}) + $signed((ACC_W+1)'(HALF));
    q = t[ACC_W:SH];
    if (q > QMAX)      return {1'b1, OMAX};
    else if (q < QMIN) return {1'b1, OMIN};
    else               return {1'b0, q[OUT_W-1:0]};
  endfunction

  logic [OUT_W:0] fmt_w;
  assign fmt_w = round_sat(in_acc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      smp_vld <= 1'b0;
      smp     <= '0;
      ovr     <= 1'b0;
    end else begin
      smp_vld <= in_vld;
      if (in_vld) begin
        ovr <= fmt_w[OUT_W];
        smp <= fmt_w[OUT_W-1:0];
      end
    end
  end

  // R6
  clamp_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovr |-> (smp == OMAX || smp == OMIN));

  // R9
  fmt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> ($stable(smp) && $stable(ovr)));

endmodule

// File: rtl/decim_chan.sv
module decim_chan
  import decim_pkg::*;
#(
  parameter int OUT_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ce,
  input  logic                    bit_in,
  output logic                    smp_vld,
  output logic signed [OUT_W-1:0] smp,
  output logic                    ovr
);

  localparam int W0 = IN_BITS;
  localparam int W1 = stg_in_w(1);
  localparam int W2 = stg_in_w(2);
  localparam int W3 = stg_in_w(3);
  localparam int SH = FS_LOG2 - (OUT_W - 1);

  logic signed [W0-1:0] s0_dat;
  logic signed [W1-1:0] s1_dat;
  logic signed [W2-1:0] s2_dat;
  logic signed [W3-1:0] s3_dat;
  logic s1_vld, s2_vld, s3_vld;

  // 1 -> +1, 0 -> -1
  assign s0_dat = bit_in ? W0'(1) : '1;

  decim_stage #(.STG(0), .IN_W(W0)) u_stg0 (
    .clk(clk), .rst_n(rst_n), .in_vld(ce), .in_dat(s0_dat),
    .out_vld(s1_vld), .out_dat(s1_dat));

  decim_stage #(.STG(1), .IN_W(W1)) u_stg1 (
    .clk(clk), .rst_n(rst_n), .in_vld(s1_vld), .in_dat(s1_dat),
    .out_vld(s2_vld), .out_dat(s2_dat));

  decim_stage #(.STG(2), .IN_W(W2)) u_stg2 (
    .clk(clk), .rst_n(rst_n), .in_vld(s2_vld), .in_dat(s2_dat),
    .out_vld(s3_vld), .out_dat(s3_dat));

  decim_outfmt #(.ACC_W(W3), .OUT_W(OUT_W), .SH(SH)) u_fmt (
    .clk(clk), .rst_n(rst_n), .in_vld(s3_vld), .in_acc(s3_dat),
    .smp_vld(smp_vld), .smp(smp), .ovr(ovr));

endmodule

// File: rtl/sdm_decim64.sv
module sdm_decim64 #(
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ce,
  input  logic             bit_l,
  input  logic             bit_r,
  output logic [OUT_W-1:0] smp_l,
  output logic [OUT_W-1:0] smp_r,
  output logic             ovr_l,
  output logic             ovr_r,
  output logic             smp_valid
);

  localparam int N_CH = 2;

  logic [N_CH-1:0]         bits_in;
  logic [N_CH-1:0]         ch_vld;
  logic [N_CH-1:0]         ch_ovr;
  logic signed [OUT_W-1:0] ch_smp [N_CH];

  assign bits_in = {bit_r, bit_l};

  genvar c;
  for (c = 0; c < N_CH; c++) begin : g_ch
    decim_chan #(.OUT_W(OUT_W)) u_chan (
      .clk(clk), .rst_n(rst_n), .ce(ce), .bit_in(bits_in[c]),
      .smp_vld(ch_vld[c]), .smp(ch_smp[c]), .ovr(ch_ovr[c]));
  end

  assign smp_l     = ch_smp[0];
  assign smp_r     = ch_smp[1];
  assign ovr_l     = ch_ovr[0];
  assign ovr_r     = ch_ovr[1];
  assign smp_valid = &ch_vld;

  // R7
  chan_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ch_vld[0] == ch_vld[1]);

endmodule

// File: tb/sdm_decim64_bench.sv
module sdm_decim64_bench;

  localparam int OUT_W    = 16;
  localparam int FRAME    = 64;
  localparam int CLK_HALF = 10;
  localparam int MAXN     = 4096;
  localparam int C3 [16] = '{509, 1031, 2039, 3079, 4093, 5639, 7159, 9219,
                             9219, 7159, 5639, 4093, 3079, 2039, 1031, 509};
  // {left pattern, right pattern}, bit n of a stream = pattern[n % 8]
  localparam logic [15:0] VEC [8] = '{16'hFF00, 16'hAA55, 16'hEE11, 16'hFE01,
                                      16'hF00F, 16'hB66D, 16'h7F80, 16'hDA24};

  logic clk = 1'b0, rst_n = 1'b0, ce = 1'b0, bit_l = 1'b0, bit_r = 1'b0;
  logic [OUT_W-1:0] smp_l, smp_r;
  logic ovr_l, ovr_r, smp_valid;

  sdm_decim64 #(.OUT_W(OUT_W)) u_sdm_decim64 (
    .clk(clk), .rst_n(rst_n), .ce(ce), .bit_l(bit_l), .bit_r(bit_r),
    .smp_l(smp_l), .smp_r(smp_r), .ovr_l(ovr_l), .ovr_r(ovr_r),
    .smp_valid(smp_valid));

  always #CLK_HALF clk = ~clk;

  int n_tests = 0, n_fail = 0;
  int xs [2][MAXN];
  int n_ce = 0, edge_n = 0, due_edge = -1, due_frame = 0, n_spur = 0;
  bit done = 1'b0;

  function automatic int xv(input int ch, input int n);
    return (n < 0) ? 0 : xs[ch][n];
  endfunction
  function automatic int y1(input int ch, input int m);
    if (m < 0) return 0;
    return xv(ch, 2*m+1) + 2*xv(ch, 2*m) + xv(ch, 2*m-1);
  endfunction
  function automatic int y2(input int ch, input int k);
    if (k < 0) return 0;
    return y1(ch, 2*k+1) + 2*y1(ch, 2*k) + y1(ch, 2*k-1);
  endfunction
  function automatic int y3(input int ch, input int j);
    int s;
    s = 0;
    for (int i = 0; i < 16; i++) s += C3[i] * y2(ch, 16*j + 15 - i);
    return s;
  endfunction
  function automatic int rnd(input int ch, input int j);
    return (y3(ch, j) + 16) >>> 5;
  endfunction
  function automatic int exp_val(input int ch, input int j);
    int r;
    r = rnd(ch, j);
    if (r > 32767) return 32767;
    if (r < -32768) return -32768;
    return r;
  endfunction
  function automatic int exp_ovr(input int ch, input int j);
    int r;
    r = rnd(ch, j);
    return (r > 32767 || r < -32768) ? 1 : 0;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic check_frame(input int j);
    int al, ar, el, er;
    al = int'($signed(smp_l));
    ar = int'($signed(smp_r));
    el = exp_val(0, j);
    er = exp_val(1, j);
    check(smp_valid == 1'b1, "R2 valid pulse timing", int'(smp_valid), 1);
    check(al == el, "R1 R3 R4 R5 R7 left sample", al, el);
    check(ar == er, "R1 R3 R4 R5 R7 right sample", ar, er);
    check(int'(ovr_l) == exp_ovr(0, j), "R6 left flag", int'(ovr_l), exp_ovr(0, j));
    check(int'(ovr_r) == exp_ovr(1, j), "R6 right flag", int'(ovr_r), exp_ovr(1, j));
  endtask

  task automatic step(input logic c, input logic bl, input logic br);
    ce = c; bit_l = bl; bit_r = br;
    @(posedge clk);
    edge_n++;
    if (c && n_ce < MAXN) begin
      xs[0][n_ce] = bl ? 1 : -1;
      xs[1][n_ce] = br ? 1 : -1;
      n_ce++;
      if (n_ce % FRAME == 0) begin
        due_edge  = edge_n + 3;
        due_frame = n_ce / FRAME - 1;
      end
    end
    @(negedge clk);
    if (edge_n == due_edge) check_frame(due_frame);
    else if (smp_valid) n_spur++;
  endtask

  task automatic run_pat(input logic [7:0] pl, input logic [7:0] pr,
                         input int nsamp, input bit gap);
    for (int k = 0; k < nsamp; k++) begin
      step(1'b1, pl[n_ce % 8], pr[n_ce % 8]);
      if (gap) step(1'b0, k[0], ~k[0]);
    end
    repeat (4) step(1'b0, 1'b0, 1'b0);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; ce = 1'b0;
    repeat (3) @(negedge clk);
    // R10
    check(smp_l == '0, "R10 left sample in reset", int'(smp_l), 0);
    check(smp_r == '0, "R10 right sample in reset", int'(smp_r), 0);
    check({ovr_l, ovr_r, smp_valid} == 3'b000, "R10 flags and valid in reset",
          int'({ovr_l, ovr_r, smp_valid}), 0);
    rst_n = 1'b1;
    n_ce = 0; due_edge = -1;
  endtask

  initial begin
    logic [OUT_W-1:0] hold_l, hold_r;
    int spur0;
    do_reset();

    // table of stimulus patterns, each checked frame by frame
    for (int v = 0; v < 8; v++) begin
      do_reset();
      run_pat(VEC[v][15:8], VEC[v][7:0], 4*FRAME, 1'b0);
    end

    // R6 R1: steady full-scale streams
    do_reset();
    run_pat(8'hFF, 8'h00, 3*FRAME, 1'b0);
    check(int'($signed(smp_l)) == 32767, "R6 ones clamp value", int'($signed(smp_l)), 32767);
    check(ovr_l == 1'b1, "R6 ones clamp flag", int'(ovr_l), 1);
    check(int'($signed(smp_r)) == -32768, "R1 R6 zeros value", int'($signed(smp_r)), -32768);
    check(ovr_r == 1'b0, "R1 R6 zeros no flag", int'(ovr_r), 0);
    run_pat(8'hAA, 8'hAA, 2*FRAME, 1'b0);
    check(ovr_l == 1'b0, "R6 flag clears", int'(ovr_l), 0);

    // R8 R9: enable low holds everything, bits ignored
    do_reset();
    run_pat(8'hEE, 8'h11, FRAME, 1'b0);
    hold_l = smp_l; hold_r = smp_r; spur0 = n_spur;
    for (int k = 0; k < 150; k++) step(1'b0, k[0], k[1]);
    check(smp_l == hold_l, "R9 left hold", int'(smp_l), int'(hold_l));
    check(smp_r == hold_r, "R9 right hold", int'(smp_r), int'(hold_r));
    check(n_spur == spur0, "R8 no pulse while idle", n_spur, spur0);
    run_pat(8'hEE, 8'h11, 2*FRAME, 1'b1);

    // R10: reset in the middle of a frame
    do_reset();
    run_pat(8'hF0, 8'h0F, 100, 1'b0);
    do_reset();
    run_pat(8'hB6, 8'h6D, 2*FRAME, 1'b0);

    check(n_spur == 0, "R2 R8 stray valid pulses", n_spur, 0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    done = 1'b1;
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule